// File: doc/BRIEF.md
# Static Memory Bus Cycle Sequencer

This block drives the active-low chip select, read strobe and write strobe for one chip select of an asynchronous external memory bus. Each access is accepted from a single-cycle request and then runs on one internal cycle count. The chip select and the read/write strobe each have their own programmable setup, pulse and hold. A strobe is low from the end of its setup until the end of its pulse, and the access lasts as long as the longer of the two windows.

Configuration bits choose which signal controls a read and which controls a write: the chip select or the direction strobe. The controlling signal matters in two places. On a read, its rising edge starts a programmable data-float period, and `busy_o` is high during that period. Its pulse is also the only window in which the synchronized external wait input has any effect. The wait input can freeze the whole cycle, or it can hold the cycle only at the last pulse cycle. When float optimization is on, a new request is taken while the bus is still floating. The new access is then delayed only as much as needed, so that its controlling strobe cannot assert before the float period ends.

Top module: `smc_cycle_seq`

## Requirements
- R1: After reset and whenever no access is running, `cs_no`, `rd_no` and `we_no` are high and `done_o` is low. After reset, `busy_o` is low and `ready_o` is high.
- R2: Cycle 0 of an access is the first cycle after the clock edge that accepts the request. A window with setup S and pulse P holds its strobe low in cycles S to S+P-1. This applies to NCS and to the read/write strobe, each with its own values. The access lasts max(S+P+H over both windows, 1) cycles, and `done_o` is high only in the last of them.
- R3: A read (`we_i`=0) uses `rd_no` and a write (`we_i`=1) uses `we_no`. Both are never low together.
- R4: `rd_by_strobe_i`=1 makes `rd_no` the read's controlling signal and 0 makes NCS the controlling signal. `wr_by_strobe_i` does the same for writes with `we_no`.
- R5: A read with a nonzero float count F raises `busy_o` for exactly F cycles, beginning in the cycle in which the controlling signal returns high. A write never raises `busy_o`.
- R6: While `busy_o` is high and float optimization is off, `ready_o` is low and a held request is not accepted.
- R7: With `float_opt_i`=1, a request is accepted during the float period. The new access's controlling strobe first asserts in the first cycle in which `busy_o` is low, or at its own setup if that comes later.
- R8: `wait_mode_i` encodes 00 as off, 01 as reserved, 10 as frozen and 11 as ready. Under 00 and 01 the wait input has no effect.
- R9: `wait_ni` passes through two flops before use, so a level first present in cycle k acts in cycle k+2.
- R10: In frozen mode, a low synchronized wait while the controlling signal's pulse is running stops the cycle count and holds every strobe at its level. The access resumes where it stopped.
- R11: In ready mode, the cycle count stays at the last pulse cycle of the controlling signal while the synchronized wait is low.
- R12: Outside the controlling signal's pulse, a low wait input has no effect in either active mode.
- R13: `cfg_err_o` is high when the wait mode is frozen or ready and the hold of the read or write controlling signal is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | Direction of the request: 1 write, 0 read |
| ready_o | output | 1 | Sequencer can accept a request this cycle |
| cs_setup_i | input | TW | NCS setup cycles |
| cs_pulse_i | input | TW | NCS pulse cycles |
| cs_hold_i | input | TW | NCS hold cycles |
| st_setup_i | input | TW | Read/write strobe setup cycles |
| st_pulse_i | input | TW | Read/write strobe pulse cycles |
| st_hold_i | input | TW | Read/write strobe hold cycles |
| rd_by_strobe_i | input | 1 | Reads controlled by the read strobe (1) or by NCS (0) |
| wr_by_strobe_i | input | 1 | Writes controlled by the write strobe (1) or by NCS (0) |
| wait_mode_i | input | 2 | Wait input handling: 00 off, 01 reserved, 10 frozen, 11 ready |
| float_cycles_i | input | FW | Float cycles after a read |
| float_opt_i | input | 1 | Let float cycles overlap the next access's setup |
| wait_ni | input | 1 | External wait, active low, asynchronous |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| done_o | output | 1 | High in the last cycle of an access |
| busy_o | output | 1 | Float period running |
| cfg_err_o | output | 1 | Wait mode active with a zero controlling hold |

## Verification
The hardest case to reach is the wait input acting at a chosen cycle count. It passes through a two-cycle synchronizer, and it only matters when it lines up with the controlling pulse. The bench therefore starts every wait pulse at a fixed number of falling edges after the access begins. One configuration puts the synchronized low inside the setup phase and another puts it inside the pulse. The resulting access length shows the synchronizer depth and the phase gating. Frozen and ready behaviour are told apart with one waveform whose low starts before the pulse ends, because the two modes then stretch the access by different amounts. The overlapped float case needs a float count longer than the next access's setup, so that the start delay can be seen at the first read strobe.

// File: rtl/smc_seq_pkg.sv
package smc_seq_pkg;
  typedef enum logic [1:0] {
    WAIT_OFF    = 2'b00,
    WAIT_RSV    = 2'b01,
    WAIT_FREEZE = 2'b10,
    WAIT_READY  = 2'b11
  } wait_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DLY,
    ST_ACT
  } seq_state_e;
endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '1;
    else         r_q <= {r_q[STAGES-2:0], d_i};
  end

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/smc_window.sv
module smc_window #(
  parameter int TW = 6,
  parameter int CW = 8
) (
  input  logic          en_i,
  input  logic [CW-1:0] t_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] pulse_i,
  input  logic [TW-1:0] hold_i,
  output logic          act_o,
  output logic          last_o,
  output logic [CW-1:0] span_o
);
  logic [CW-1:0] beg_c, end_c;

  assign beg_c  = CW'(setup_i);
  assign end_c  = beg_c + CW'(pulse_i);
  assign act_o  = en_i && (t_i >= beg_c) && (t_i < end_c);
  assign last_o = en_i && (pulse_i != '0) && (t_i == end_c - 1'b1);
  assign span_o = end_c + CW'(hold_i);
endmodule

// File: rtl/smc_float.sv
module smc_float #(
  parameter int FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [FW-1:0] val_i,
  output logic [FW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (load_i)        cnt_o <= val_i;
    else if (cnt_o != '0)   cnt_o <= cnt_o - 1'b1;
  end

  // R5: float period drains one per cycle
  a_r5_float_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0 && !load_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/smc_cycle_seq.sv
module smc_cycle_seq
  import smc_seq_pkg::*;
#(
  parameter int TW          = 6,
  parameter int FW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  output logic          ready_o,
  input  logic [TW-1:0] cs_setup_i,
  input  logic [TW-1:0] cs_pulse_i,
  input  logic [TW-1:0] cs_hold_i,
  input  logic [TW-1:0] st_setup_i,
  input  logic [TW-1:0] st_pulse_i,
  input  logic [TW-1:0] st_hold_i,
  input  logic          rd_by_strobe_i,
  input  logic          wr_by_strobe_i,
  input  logic [1:0]    wait_mode_i,
  input  logic [FW-1:0] float_cycles_i,
  input  logic          float_opt_i,
  input  logic          wait_ni,
  output logic          cs_no,
  output logic          rd_no,
  output logic          we_no,
  output logic          done_o,
  output logic          busy_o,
  output logic          cfg_err_o
);
  // cycle count covers three full 6-bit phases; FW must not exceed CW
  localparam int CW = TW + 2;

  seq_state_e    state_q;
  logic [CW-1:0] t_q, dly_q;
  logic          we_q;
  logic          in_act;
  logic          wait_s;
  wait_mode_e    mode;
  logic [FW-1:0] fcnt;

  smc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wait_ni),
    .q_o   (wait_s)
  );

  // window 0: chip select, window 1: read/write strobe
  logic [1:0][TW-1:0] w_setup, w_pulse, w_hold;
  logic [1:0]         w_act, w_last;
  logic [1:0][CW-1:0] w_span;

  assign in_act  = (state_q == ST_ACT);
  assign w_setup = {st_setup_i, cs_setup_i};
  assign w_pulse = {st_pulse_i, cs_pulse_i};
  assign w_hold  = {st_hold_i,  cs_hold_i};

  for (genvar g = 0; g < 2; g++) begin : g_win
    smc_window #(.TW(TW), .CW(CW)) u_win (
      .en_i   (in_act),
      .t_i    (t_q),
      .setup_i(w_setup[g]),
      .pulse_i(w_pulse[g]),
      .hold_i (w_hold[g]),
      .act_o  (w_act[g]),
      .last_o (w_last[g]),
      .span_o (w_span[g])
    );
  end

  assign mode = wait_mode_e'(wait_mode_i);

  logic ctl_sel, ctl_act, ctl_last, stall, fin, f_load;
  logic [CW-1:0] span_max, t_last;

  assign ctl_sel  = we_q ? wr_by_strobe_i : rd_by_strobe_i;
  assign ctl_act  = ctl_sel ? w_act[1]  : w_act[0];
  assign ctl_last = ctl_sel ? w_last[1] : w_last[0];

  assign stall = in_act && !wait_s &&
                 ((mode == WAIT_FREEZE && ctl_act) ||
                  (mode == WAIT_READY  && ctl_last));

  assign span_max = (w_span[0] > w_span[1]) ? w_span[0] : w_span[1];
  assign t_last   = (span_max == '0) ? '0 : span_max - 1'b1;
  assign fin      = in_act && !stall && (t_q == t_last);
  assign done_o   = fin;

  // float starts when the read controlling signal rises
  assign f_load = in_act && !we_q && ctl_last && !stall && (float_cycles_i != '0);

  smc_float #(.FW(FW)) u_float (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(f_load),
    .val_i (float_cycles_i),
    .cnt_o (fcnt)
  );

  assign busy_o = (fcnt != '0);

  // start delay so the new controlling strobe waits for the float to end
  logic          new_sel, accept;
  logic [CW-1:0] new_setup, f_rem, dly_need;

  assign ready_o   = (state_q == ST_IDLE) && (!busy_o || float_opt_i);
  assign accept    = req_i && ready_o;
  assign new_sel   = we_i ? wr_by_strobe_i : rd_by_strobe_i;
  assign new_setup = CW'(new_sel ? st_setup_i : cs_setup_i);
  assign f_rem     = busy_o ? CW'(fcnt) - 1'b1 : '0;
  assign dly_need  = (float_opt_i && f_rem > new_setup) ? f_rem - new_setup : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
      dly_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          we_q <= we_i;
          t_q  <= '0;
          if (dly_need != '0) begin
            dly_q   <= dly_need;
            state_q <= ST_DLY;
          end else begin
            state_q <= ST_ACT;
          end
        end
        ST_DLY: begin
          if (dly_q == CW'(1)) state_q <= ST_ACT;
          else                 dly_q   <= dly_q - 1'b1;
        end
        ST_ACT: begin
          if (fin)         state_q <= ST_IDLE;
          else if (!stall) t_q     <= t_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no = !w_act[0];
  assign rd_no = !(w_act[1] && !we_q);
  assign we_no = !(w_act[1] &&  we_q);

  logic [TW-1:0] rd_ctl_hold, wr_ctl_hold;
  assign rd_ctl_hold = rd_by_strobe_i ? st_hold_i : cs_hold_i;
  assign wr_ctl_hold = wr_by_strobe_i ? st_hold_i : cs_hold_i;
  assign cfg_err_o   = (mode == WAIT_FREEZE || mode == WAIT_READY) &&
                       (rd_ctl_hold == '0 || wr_ctl_hold == '0);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_act |-> (cs_no && rd_no && we_no && !done_o));

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> we_no);

  a_r6_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !float_opt_i) |-> !ready_o);

  a_r7_float_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_act && ctl_act) |-> !busy_o);

  a_r8_off_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_act && !fin && (mode == WAIT_OFF || mode == WAIT_RSV)) |=> (t_q == $past(t_q) + 1'b1));

  a_r10_freeze_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == WAIT_FREEZE && stall) |=> $stable({cs_no, rd_no, we_no}));
endmodule

// File: tb/test_smc_cycle_seq.sv
`timescale 1ns/1ps
module test_smc_cycle_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       req = 1'b0, we = 1'b0;
  logic [5:0] cs_s = '0, cs_p = '0, cs_h = '0, st_s = '0, st_p = '0, st_h = '0;
  logic       rd_by = 1'b0, wr_by = 1'b0, fopt = 1'b0, wait_n = 1'b1;
  logic [1:0] wmode = 2'b00;
  logic [3:0] fcyc = '0;
  logic       ready_o, cs_no, rd_no, we_no, done_o, busy_o, cfg_err_o;

  smc_cycle_seq i_smc_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .ready_o(ready_o),
    .cs_setup_i(cs_s), .cs_pulse_i(cs_p), .cs_hold_i(cs_h),
    .st_setup_i(st_s), .st_pulse_i(st_p), .st_hold_i(st_h),
    .rd_by_strobe_i(rd_by), .wr_by_strobe_i(wr_by), .wait_mode_i(wmode),
    .float_cycles_i(fcyc), .float_opt_i(fopt), .wait_ni(wait_n),
    .cs_no(cs_no), .rd_no(rd_no), .we_no(we_no), .done_o(done_o),
    .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, errors = 0;
  int len, csl, rdf, bsy, n;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic set_t(input int a, b, c, d, e, f);
    cs_s = 6'(a); cs_p = 6'(b); cs_h = 6'(c);
    st_s = 6'(d); st_p = 6'(e); st_h = 6'(f);
  endtask

  task automatic settle;
    @(negedge clk);
    while (!ready_o || busy_o) @(negedge clk);
  endtask

  // returns at the falling edge of access cycle 0
  task automatic issue(input bit w);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    we = w; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic measure(output int l, output int cl, output int rf, output int ba);
    l = 0; cl = 0; rf = -1; ba = -1;
    for (int i = 0; i < 400; i++) begin
      if (!cs_no) cl++;
      if (!rd_no && rf < 0) begin rf = i; ba = int'(busy_o); end
      if (done_o) begin l = i + 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic count_not_ready(output int k);
    k = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (ready_o) break;
      k++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_no && rd_no && we_no && !done_o && !busy_o && ready_o, "R1 reset",
        int'({cs_no, rd_no, we_no, done_o, busy_o, ready_o}), 6'b111001);

    // R2 R3: sweep of all setup/pulse/hold combinations 0..2
    n = 0;
    for (int a = 0; a < 3; a++) for (int b = 0; b < 3; b++) for (int c = 0; c < 3; c++)
    for (int d = 0; d < 3; d++) for (int e = 0; e < 3; e++) for (int f = 0; f < 3; f++) begin
      int lx;
      bit w;
      set_t(a, b, c, d, e, f);
      rd_by = n[0]; wr_by = n[1]; w = n[2];
      n++;
      lx = (a + b + c > d + e + f) ? a + b + c : d + e + f;
      if (lx == 0) lx = 1;
      issue(w);
      for (int i = 0; i < lx; i++) begin
        bit ecs, est;
        logic [3:0] exp_v, act_v;
        ecs = (i >= a) && (i < a + b);
        est = (i >= d) && (i < d + e);
        exp_v = {!ecs, !(est && !w), !(est && w), i == lx - 1};
        act_v = {cs_no, rd_no, we_no, done_o};
        chk(act_v == exp_v, w ? "R2 R3 write timing" : "R2 R3 read timing", int'(act_v), int'(exp_v));
        @(negedge clk);
      end
      chk(cs_no && rd_no && we_no && !done_o, "R1 idle after access",
          int'({cs_no, rd_no, we_no, done_o}), 4'b1110);
    end

    // R4 R5: float start follows the controlling signal
    set_t(0, 5, 0, 1, 2, 2); fcyc = 4;
    settle; rd_by = 1'b1;
    issue(0); measure(len, csl, rdf, bsy);
    count_not_ready(n);
    chk(n == 2, "R4 R5 float after read strobe", n, 2);
    settle; rd_by = 1'b0;
    issue(0); measure(len, csl, rdf, bsy);
    count_not_ready(n);
    chk(n == 4, "R4 R5 float after chip select", n, 4);
    settle; wr_by = 1'b1;
    issue(1); measure(len, csl, rdf, bsy);
    count_not_ready(n);
    chk(n == 0, "R5 write sets no float", n, 0);

    // R6: held request waits out the float period
    settle; rd_by = 1'b1;
    issue(0); measure(len, csl, rdf, bsy);
    @(negedge clk);
    chk(busy_o && !ready_o, "R6 busy blocks", int'({busy_o, ready_o}), 2'b10);
    we = 1'b0; req = 1'b1; n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); n++;
      if (!cs_no) break;
    end
    req = 1'b0;
    chk(n == 3, "R6 request accepted after float", n, 3);
    measure(len, csl, rdf, bsy);
    chk(len == 5, "R6 access length", len, 5);

    // R7: overlapped float delays the next controlling strobe
    settle; fcyc = 8; fopt = 1'b1; rd_by = 1'b1;
    issue(0); measure(len, csl, rdf, bsy);
    issue(0); measure(len, csl, rdf, bsy);
    chk(len == 9, "R7 delayed access length", len, 9);
    chk(rdf == 5, "R7 first read strobe cycle", rdf, 5);
    chk(bsy == 0, "R7 float over at strobe", bsy, 0);
    fopt = 1'b0; fcyc = 0;

    // R10 frozen: wait low in cycles 1..3, synchronized low in 3..5
    settle; set_t(0, 4, 1, 1, 2, 1); rd_by = 1'b0; wmode = 2'b10;
    issue(0);
    fork
      measure(len, csl, rdf, bsy);
      begin @(negedge clk); wait_n = 1'b0; repeat (3) @(negedge clk); wait_n = 1'b1; end
    join
    chk(len == 8, "R10 frozen length", len, 8);
    chk(csl == 7, "R10 frozen chip select low", csl, 7);

    // R11 ready vs R8 off/reserved: wait low in cycles 0..4
    wmode = 2'b11; settle; issue(0);
    fork
      measure(len, csl, rdf, bsy);
      begin wait_n = 1'b0; repeat (5) @(negedge clk); wait_n = 1'b1; end
    join
    chk(len == 9, "R11 ready length", len, 9);
    chk(csl == 8, "R11 ready chip select low", csl, 8);
    for (int m = 0; m < 2; m++) begin
      wmode = 2'(m); settle; issue(0);
      fork
        measure(len, csl, rdf, bsy);
        begin wait_n = 1'b0; repeat (5) @(negedge clk); wait_n = 1'b1; end
      join
      chk(len == 5, m == 0 ? "R8 wait off ignored" : "R8 wait reserved ignored", len, 5);
    end

    // R9: synchronizer depth, pulse starts in cycle 3
    wmode = 2'b10; settle; set_t(3, 3, 1, 0, 0, 0); issue(0);
    fork
      measure(len, csl, rdf, bsy);
      begin wait_n = 1'b0; @(negedge clk); wait_n = 1'b1; end
    join
    chk(len == 7, "R9 low in cycle 0 acts in setup", len, 7);
    settle; issue(0);
    fork
      measure(len, csl, rdf, bsy);
      begin @(negedge clk); wait_n = 1'b0; @(negedge clk); wait_n = 1'b1; end
    join
    chk(len == 8, "R9 low in cycle 1 acts in pulse", len, 8);

    // R12: low during setup only
    settle; set_t(4, 2, 1, 0, 0, 0); issue(0);
    fork
      measure(len, csl, rdf, bsy);
      begin wait_n = 1'b0; repeat (2) @(negedge clk); wait_n = 1'b1; end
    join
    chk(len == 7, "R12 wait outside pulse", len, 7);

    // R13: configuration error
    settle;
    wmode = 2'b10; rd_by = 1'b0; wr_by = 1'b0; set_t(0, 1, 0, 0, 1, 1); #1;
    chk(cfg_err_o == 1'b1, "R13 frozen zero hold", int'(cfg_err_o), 1);
    wmode = 2'b00; #1;
    chk(cfg_err_o == 1'b0, "R13 off zero hold", int'(cfg_err_o), 0);
    wmode = 2'b11; rd_by = 1'b1; wr_by = 1'b1; set_t(0, 1, 1, 0, 1, 0); #1;
    chk(cfg_err_o == 1'b1, "R13 ready zero strobe hold", int'(cfg_err_o), 1);
    set_t(0, 1, 0, 0, 1, 1); #1;
    chk(cfg_err_o == 1'b0, "R13 ready nonzero hold", int'(cfg_err_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule